// File: doc/BRIEF.md
# Register-Controlled MDIO Management Master

This block runs single management-bus transactions toward an Ethernet PHY. Software sets up three word registers: a command word, a data word and a status word. It starts one Clause 22 read or write frame on the MDC/MDIO pins with a single write to the command word. The MDC clock is derived from the system clock by a fixed divider. A frame opens with 32 preamble ones, followed by the start pattern, the opcode, the PHY and register addresses, the turnaround and 16 data bits sent MSB first.

While a frame is running, the start bit of the command word reads back as 1. Software polls it to find out when the engine is idle again. For a write, software first puts the value in the low half of the data word. After a read, the returned value sits in the upper half of the data word. The status word then tells whether a PHY answered the read.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset all three words read 0, MDC is low and the MDIO output enable is low.
- R2: Register selection is `reg_addr` 0 = command, 1 = data, 2 = status. The command word fields are:
  - bit 20: start.
  - bit 17: read. It wins if bit 16 is also set.
  - bit 16: write.
  - bits 12:8: PHY address.
  - bits 4:0: register address.
  - Reads of the command word return the latched op, PHY and register fields in those same positions.
- R3: A frame is 32 ones, then 01, then the opcode (10 = read, 01 = write), the 5-bit PHY address, the 5-bit register address, the turnaround and 16 data bits, all MSB first. A write's turnaround is 10 and its data is the low half of the data word.
- R4: MDC idles low and has HALF_CYCLES clocks low then HALF_CYCLES clocks high per period. During a frame the MDIO output changes only where MDC falls.
- R5: Command bit 20 reads 1 from the cycle after an accepted start until the frame ends, then reads 0.
- R6: For a read, the output enable is low for both turnaround bits and all 16 data bits. The data bits are sampled on MDC rising edges into bits 31:16 of the data word.
- R7: Status bit 0 is set at the end of a read if the second turnaround bit was sampled high (no PHY answered), and cleared if it was low. Write frames leave it unchanged.
- R8: While a frame runs, command writes and data writes are ignored.
- R9: A command write with the start bit set but neither op bit set starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pad |

## Verification
The hardest situation to reach from the ports is a read whose turnaround gets no answer. The bench's PHY model can be told to stay silent, so the pulled-up line is sampled high on the second turnaround bit. A later read with the PHY answering must then clear the flag. In between, a write frame must leave it set. The other hard-to-reach cases are a second command and a data write landing mid-frame. The bench issues these a few cycles after a start, then confirms through the scoreboard that only one frame appeared on the wire, and through the data and command words that nothing was overwritten.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  localparam int START_BIT = 20;
  localparam int RD_BIT    = 17;
  localparam int WR_BIT    = 16;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [4:0] phy;
    logic [4:0] regad;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap      = run && (cnt == CNT_TOP);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_cmd_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        launch,
  input  mdio_cmd_t   cmd,
  input  logic [15:0] wr_word,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_word,
  output logic        rd_bad
);
  localparam int FRAME_W  = PRE_LEN + 32;
  localparam int IDX_W    = $clog2(FRAME_W);
  localparam int TA_IDX   = PRE_LEN + 14;
  localparam int DATA_IDX = PRE_LEN + 16;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TA_PRE   = IDX_W'(TA_IDX - 1);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_IDX + 1);
  localparam logic [IDX_W-1:0] D0_IDX   = IDX_W'(DATA_IDX);

  logic [FRAME_W-1:0] shreg;
  logic [FRAME_W-1:0] frame_new;
  logic [IDX_W-1:0]   idx;
  logic               is_rd;
  logic               at_end;

  assign frame_new = {{PRE_LEN{1'b1}}, 2'b01,
                      cmd.rd ? 2'b10 : 2'b01,
                      cmd.phy, cmd.regad,
                      cmd.rd ? 2'b11 : 2'b10,
                      cmd.rd ? 16'hFFFF : wr_word};
  assign at_end  = busy && fall_tick && (idx == LAST_IDX);
  assign rd_done = at_end && is_rd;
  assign mdio_o  = shreg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      is_rd   <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      mdio_oe <= 1'b0;
      rd_word <= '0;
      rd_bad  <= 1'b0;
    end else if (!busy) begin
      if (launch) begin
        busy    <= 1'b1;
        is_rd   <= cmd.rd;
        shreg   <= frame_new;
        idx     <= '0;
        mdio_oe <= 1'b1;
      end
    end else begin
      if (rise_tick && is_rd) begin
        if (idx == TA2_IDX) rd_bad <= mdio_i;
        if (idx >= D0_IDX)  rd_word <= {rd_word[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (idx == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          shreg <= {shreg[FRAME_W-2:0], 1'b0};
          idx   <= idx + 1'b1;
          if (is_rd && idx == TA_PRE) mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic        rd_done,
  input  logic [15:0] rd_word,
  input  logic        rd_bad,
  output logic        launch,
  output mdio_cmd_t   cmd_new,
  output mdio_cmd_t   cmd_q,
  output logic [15:0] wr_word,
  output logic [31:0] rdata
);
  logic        cmd_hit;
  logic        data_hit;
  logic [15:0] rd_q;
  logic        stat_q;
  logic        unused_bits;

  assign cmd_hit  = wr_en && !busy && (addr == SEL_CMD);
  assign data_hit = wr_en && !busy && (addr == SEL_DATA);
  assign cmd_new  = '{rd: wdata[RD_BIT], wr: wdata[WR_BIT],
                      phy: wdata[12:8], regad: wdata[4:0]};
  assign launch   = cmd_hit && wdata[START_BIT] &&
                    (wdata[RD_BIT] || wdata[WR_BIT]);
  assign unused_bits = ^{wdata[31:21], wdata[19:18], wdata[15:13], wdata[7:5]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      wr_word <= '0;
      rd_q    <= '0;
      stat_q  <= 1'b0;
      rdata   <= '0;
    end else begin
      if (cmd_hit)  cmd_q   <= cmd_new;
      if (data_hit) wr_word <= wdata[15:0];
      if (rd_done) begin
        rd_q   <= rd_word;
        stat_q <= rd_bad;
      end
      case (addr)
        SEL_CMD:  rdata <= {11'd0, busy, 2'b00, cmd_q.rd, cmd_q.wr, 3'b000,
                            cmd_q.phy, 3'b000, cmd_q.regad};
        SEL_DATA: rdata <= {rd_q, wr_word};
        SEL_STAT: rdata <= {31'd0, stat_q};
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int PRE_LEN     = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        launch;
  mdio_cmd_t   cmd_new;
  mdio_cmd_t   cmd_q;
  logic [11:0] cmd_fields;
  logic [15:0] wr_word;
  logic        eng_busy;
  logic        rd_done;
  logic [15:0] rd_word;
  logic        rd_bad;
  logic        rise_tick;
  logic        fall_tick;

  assign cmd_fields = cmd_q;

  mdio_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .busy(eng_busy), .rd_done(rd_done), .rd_word(rd_word), .rd_bad(rd_bad),
    .launch(launch), .cmd_new(cmd_new), .cmd_q(cmd_q), .wr_word(wr_word),
    .rdata(reg_rdata)
  );

  mdio_mdc_gen #(.HALF_CYCLES(HALF_CYCLES)) u_mdc (
    .clk(clk), .rst(rst), .run(eng_busy), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .cmd(cmd_new), .wr_word(wr_word),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(eng_busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_done(rd_done),
    .rd_word(rd_word), .rd_bad(rd_bad)
  );
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [31:0] wdata,
  input logic        busy,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic [11:0] cmd_fields
);
  assert_start_from_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && addr == 2'd0 && wdata[20]));

  assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  assert_mdio_moves_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  assert_oe_only_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);

  assert_cmd_held_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cmd_fields));

  assert_noop_start_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0 && wdata[20] && !wdata[17] && !wdata[16] && !busy)
      |=> !busy);
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
  .busy(eng_busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .cmd_fields(cmd_fields)
);

// File: tb/mdio_cmd_engine_bench.sv
`timescale 1ns/1ps
module mdio_cmd_engine_bench;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  logic        phy_drv = 1'b0;
  logic        phy_val = 1'b1;
  logic        phy_present = 1'b1;
  logic [15:0] phy_rdval = 16'h0000;

  int checks = 0;
  int errors = 0;
  int frames_seen = 0;
  bit finished = 0;

  logic [63:0] exp_frame_q[$];
  bit          exp_rd_q[$];

  always #2 clk = ~clk;

  assign mdio_i = phy_drv ? phy_val : (mdio_oe ? mdio_o : 1'b1);

  mdio_cmd_engine #(.HALF_CYCLES(HALF), .PRE_LEN(32)) u_mdio_cmd_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_frame(bit rd, logic [4:0] phy,
                                           logic [4:0] ra, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra,
            rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : d};
  endfunction

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    v = 32'h0010_0000;
    while (v[20]) reg_read(2'd0, v);
  endtask

  // driver: queue expected frame, then issue the command
  task automatic run_cmd(bit rd, bit both, logic [4:0] phy, logic [4:0] ra,
                         logic [15:0] d);
    exp_frame_q.push_back(mk_frame(rd || both, phy, ra, d));
    exp_rd_q.push_back(rd || both);
    if (!rd && !both) reg_write(2'd1, {16'h0, d});
    reg_write(2'd0, (32'h1 << 20) | (rd ? 32'h1 << 17 : 32'h0) |
                    ((!rd || both) ? 32'h1 << 16 : 32'h0) |
                    ({27'd0, phy} << 8) | {27'd0, ra});
  endtask

  // PHY model and scoreboard monitor
  initial begin
    logic [63:0] cap;
    logic [63:0] exp;
    bit          rd;
    bit          e_rd;
    bit          leak;
    forever begin
      @(posedge mdio_oe);
      cap = '0; leak = 0; rd = 0;
      for (int i = 0; i < 64; i++) begin
        @(posedge mdc); #1;
        cap[63-i] = mdio_i;
        if (i >= 46 && mdio_oe) leak = 1;
        @(negedge mdc); #1;
        rd = cap[29] && !cap[28];
        if (rd && phy_present && (i + 1) >= 47 && (i + 1) <= 63) begin
          phy_drv = 1'b1;
          phy_val = ((i + 1) == 47) ? 1'b0 : phy_rdval[63 - (i + 1)];
        end else begin
          phy_drv = 1'b0;
        end
      end
      frames_seen++;
      if (exp_frame_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8 unexpected frame actual=%h expected=none", cap);
      end else begin
        exp  = exp_frame_q.pop_front();
        e_rd = exp_rd_q.pop_front();
        if (e_rd) begin
          check32("R3 read header hi", cap[63:32], exp[63:32]);
          check32("R3 read header lo", {18'd0, cap[31:18]}, {18'd0, exp[31:18]});
          check32("R6 oe released", {31'd0, leak}, 32'd0);
        end else begin
          check32("R3 write frame hi", cap[63:32], exp[63:32]);
          check32("R3 write frame lo", cap[31:0], exp[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int          n0;
    realtime     t0, t1;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_read(2'd0, v); check32("R1 cmd", v, 0);
    reg_read(2'd1, v); check32("R1 data", v, 0);
    reg_read(2'd2, v); check32("R1 status", v, 0);
    check32("R1 mdc", {31'd0, mdc}, 0);
    check32("R1 oe", {31'd0, mdio_oe}, 0);

    // write frame; R5 busy, R4 mdc period
    run_cmd(0, 0, 5'd3, 5'd4, 16'hA5A5);
    reg_read(2'd0, v);
    check32("R5 busy", {31'd0, v[20]}, 1);
    check32("R2 cmd fields", v & 32'h0003_1F1F, 32'h0001_0304);
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    check32("R4 mdc period", 32'(int'((t1 - t0) / 4.0)), 2 * HALF);
    // R8: command and data writes while busy
    reg_write(2'd0, 32'h0012_0705);
    reg_write(2'd1, 32'h0000_1234);
    wait_idle();
    reg_read(2'd0, v);
    check32("R5 idle", {31'd0, v[20]}, 0);
    check32("R8 cmd kept", v & 32'h0003_1F1F, 32'h0001_0304);
    reg_read(2'd1, v);
    check32("R8 data kept", {16'd0, v[15:0]}, 32'h0000_A5A5);
    check32("R8 one frame", frames_seen, 1);

    // R6 valid read
    phy_rdval = 16'hBEEF; phy_present = 1'b1;
    run_cmd(1, 0, 5'd5, 5'd2, 16'h0);
    wait_idle();
    reg_read(2'd1, v);
    check32("R6 read data", {16'd0, v[31:16]}, 32'h0000_BEEF);
    reg_read(2'd2, v);
    check32("R7 valid status", v, 0);

    // R7 no PHY
    phy_present = 1'b0;
    run_cmd(1, 0, 5'd9, 5'd1, 16'h0);
    wait_idle();
    reg_read(2'd2, v);
    check32("R7 invalid status", v, 1);
    reg_read(2'd1, v);
    check32("R7 floating data", {16'd0, v[31:16]}, 32'h0000_FFFF);

    // R7 write leaves status
    run_cmd(0, 0, 5'd1, 5'd31, 16'h0F0F);
    wait_idle();
    reg_read(2'd2, v);
    check32("R7 status after write", v, 1);

    // R2 both op bits -> read; R7 cleared by good read
    phy_present = 1'b1; phy_rdval = 16'h1357;
    run_cmd(1, 1, 5'd31, 5'd0, 16'h0);
    wait_idle();
    reg_read(2'd1, v);
    check32("R2 read wins", {16'd0, v[31:16]}, 32'h0000_1357);
    reg_read(2'd2, v);
    check32("R7 cleared", v, 0);

    // R9 start without op
    n0 = frames_seen;
    reg_write(2'd0, 32'h0010_0305);
    repeat (40) @(negedge clk);
    reg_read(2'd0, v);
    check32("R9 no busy", {31'd0, v[20]}, 0);
    check32("R9 no frame", frames_seen, n0);
    check32("R9 mdc low", {31'd0, mdc}, 0);

    check32("R3 queue drained", exp_frame_q.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule